// File: doc/BRIEF.md
# Ethernet Receive Frame Checker

This block sits on a byte-wide receive path in which each byte arrives with a data-valid strobe and an error strobe. It finds the start of each frame by checking a run of alternating-bit bytes that ends in a delimiter byte. It drops those leading bytes and passes every byte after the delimiter to an 8-bit output stream, one cycle later. A downstream packet buffer writes these bytes as they come.

A frame ends when data-valid goes low. One cycle later the block issues a single status pulse that carries a good/bad flag, and the buffer uses it to keep or discard what it stored. A frame is good only if all of the following hold:
- its leading sequence was well formed;
- no error strobe was seen during the frame;
- its length is within the legal range;
- its 32-bit check sequence is correct;
- its destination is either the station's own address or broadcast.

There is no group-address acceptance.

Top module: `eth_rx_frame_check`

## Requirements
- R1: A frame must open with one or more 0x55 bytes followed by 0xD5. If any other byte appears before the 0xD5, including 0xD5 as the very first byte, the frame is bad and none of its bytes are forwarded.
- R2: Every byte received after the 0xD5 delimiter appears on `out_data`, with `out_valid` high, exactly one cycle after it was received and in arrival order. Leading bytes and the delimiter are never forwarded.
- R3: The frame length counts the bytes after the delimiter, from the first destination byte through the last check byte. Only lengths from 64 to 1518 inclusive can give a good status.
- R4: The check sequence is CRC-32 with the reflected polynomial 0xEDB88320 and a start value of all ones, computed over the bytes after the delimiter. The sender appends the complement of the register, least significant byte first. The frame passes only if the register equals 0xDEBB20E3 after the last byte.
- R5: The first six bytes after the delimiter are the destination. The first of them is compared with `local_addr[47:40]` and the sixth with `local_addr[7:0]`. The frame passes only if all six match `local_addr`, or all six are 0xFF. Any other value, including group addresses, gives a bad status.
- R6: If `rx_er` is high in any cycle in which `rx_dv` is high during a frame, that frame is bad.
- R7: If `rx_dv` drops before the delimiter is seen, a bad status is still issued and no bytes are forwarded.
- R8: Each burst of `rx_dv` produces exactly one `stat_valid` pulse, one cycle long. It appears in the cycle after the first cycle in which `rx_dv` is low. `stat_good` is high with it only when R1, R3, R4, R5 and R6 all pass.
- R9: After reset, `out_valid` and `stat_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_dv | input | 1 | Receive data valid |
| rx_er | input | 1 | Receive error strobe |
| rx_d | input | 8 | Receive byte |
| local_addr | input | 48 | Station address, first received byte in bits 47:40 |
| out_valid | output | 1 | Forwarded byte valid |
| out_data | output | 8 | Forwarded frame byte |
| stat_valid | output | 1 | End-of-frame status strobe |
| stat_good | output | 1 | Frame accepted when high, qualified by stat_valid |

## Verification
The bench targets the edges of the length window: 63, 64, 1518 and 1519 bytes. A counter that is off by one, or that includes the delimiter, would flip the verdict at one of these edges.

It also sends the following malformed frames:
- a leading sequence that is only the delimiter, which catches a checker that does not demand at least one 0x55;
- a leading sequence with a stray byte in it;
- a burst that ends before its delimiter, which catches a design that stays silent instead of reporting bad;
- an error strobe on the final check byte alone, which catches a design that samples the strobe only early in the frame.

Destinations that differ only in their last byte, and group addresses, expose a filter that compares too few bytes or accepts any address with its group bit set. A corrupted check byte and randomly built frames cover the CRC byte order.

// File: rtl/efc_pkg.sv
package efc_pkg;

  localparam logic [7:0]  PRE_BYTE    = 8'h55;
  localparam logic [7:0]  SFD_BYTE    = 8'hD5;
  localparam logic [31:0] CRC_POLY    = 32'hEDB88320;
  localparam logic [31:0] CRC_INIT    = 32'hFFFFFFFF;
  localparam logic [31:0] CRC_RESIDUE = 32'hDEBB20E3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PRE   = 2'd1,
    ST_BODY  = 2'd2,
    ST_ABORT = 2'd3
  } rx_state_t;

  // One byte of reflected CRC-32, low bit first.
  function automatic logic [31:0] crc_step(input logic [31:0] crc, input logic [7:0] d);
    logic [31:0] c;
    c = crc ^ {24'h0, d};
    for (int k = 0; k < 8; k++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
    end
    return c;
  endfunction

  // Final acceptance decision from the separate checks.
  function automatic logic frame_verdict(input logic sfd_ok, input logic err,
                                         input logic len_ok, input logic crc_ok,
                                         input logic dest_ok);
    return sfd_ok && !err && len_ok && crc_ok && dest_ok;
  endfunction

endpackage

// File: rtl/efc_crc32.sv
module efc_crc32
  import efc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       en,
  input  logic [7:0] data,
  output logic       crc_ok
);

  logic [31:0] crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      crc_q <= CRC_INIT;
    end else if (en) begin
      crc_q <= crc_step(crc_q, data);
    end
  end

  assign crc_ok = (crc_q == CRC_RESIDUE);

endmodule

// File: rtl/efc_len_count.sv
module efc_len_count #(
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1518,
  parameter int LEN_W   = $clog2(MAX_LEN + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             en,
  output logic [LEN_W-1:0] count,
  output logic             len_ok
);

  localparam logic [LEN_W-1:0] SAT_VAL = LEN_W'(MAX_LEN + 1);
  localparam logic [LEN_W-1:0] LO_VAL  = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] HI_VAL  = LEN_W'(MAX_LEN);

  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt_q <= '0;
    end else if (en && cnt_q != SAT_VAL) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign count  = cnt_q;
  assign len_ok = (cnt_q >= LO_VAL) && (cnt_q <= HI_VAL);

endmodule

// File: rtl/efc_dest_filter.sv
module efc_dest_filter #(
  parameter int ADDR_W = 48,
  parameter int IDX_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [7:0]        data,
  input  logic [ADDR_W-1:0] local_addr,
  output logic              dest_ok
);

  localparam int N_BYTES = ADDR_W / 8;

  logic [N_BYTES-1:0] own_hit;
  logic [N_BYTES-1:0] sel;
  logic               own_q, bc_q;
  logic               own_byte, bc_byte, in_addr;

  for (genvar g = 0; g < N_BYTES; g++) begin : g_byte
    assign own_hit[g] = (data == local_addr[ADDR_W-1-8*g -: 8]);
    assign sel[g]     = (idx == IDX_W'(g));
  end

  assign in_addr  = |sel;
  assign own_byte = |(own_hit & sel);
  assign bc_byte  = (data == 8'hFF);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      own_q <= 1'b1;
      bc_q  <= 1'b1;
    end else if (en && in_addr) begin
      own_q <= own_q && own_byte;
      bc_q  <= bc_q && bc_byte;
    end
  end

  assign dest_ok = own_q || bc_q;

endmodule

// File: rtl/eth_rx_frame_check.sv
module eth_rx_frame_check
  import efc_pkg::*;
#(
  parameter int ADDR_W  = 48,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1518
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_dv,
  input  logic              rx_er,
  input  logic [7:0]        rx_d,
  input  logic [ADDR_W-1:0] local_addr,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              stat_valid,
  output logic              stat_good
);

  localparam int LEN_W = $clog2(MAX_LEN + 2);

  rx_state_t        state_q, state_d;
  logic             frame_start, frame_end, body_byte;
  logic             frame_active, sfd_seen, err_seen;
  logic             err_q;
  logic             len_ok, crc_ok, dest_ok;
  logic [LEN_W-1:0] byte_idx;

  // Named events used by the logic and the checker.
  assign frame_active = (state_q != ST_IDLE);
  assign sfd_seen     = (state_q == ST_BODY);
  assign frame_start  = (state_q == ST_IDLE) && rx_dv;
  assign frame_end    = frame_active && !rx_dv;
  assign body_byte    = sfd_seen && rx_dv;
  assign err_seen     = err_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (rx_dv) state_d = (rx_d == PRE_BYTE) ? ST_PRE : ST_ABORT;
      end
      ST_PRE: begin
        if (!rx_dv)                state_d = ST_IDLE;
        else if (rx_d == PRE_BYTE) state_d = ST_PRE;
        else if (rx_d == SFD_BYTE) state_d = ST_BODY;
        else                       state_d = ST_ABORT;
      end
      ST_BODY, ST_ABORT: begin
        if (!rx_dv) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          err_q <= 1'b0;
    else if (frame_start)                err_q <= rx_er;
    else if (frame_active && rx_dv && rx_er) err_q <= 1'b1;
  end

  efc_len_count #(.MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_len (
    .clk(clk), .rst_n(rst_n), .clear(frame_start), .en(body_byte),
    .count(byte_idx), .len_ok(len_ok)
  );

  efc_crc32 u_crc (
    .clk(clk), .rst_n(rst_n), .clear(frame_start), .en(body_byte),
    .data(rx_d), .crc_ok(crc_ok)
  );

  efc_dest_filter #(.ADDR_W(ADDR_W), .IDX_W(LEN_W)) u_dst (
    .clk(clk), .rst_n(rst_n), .clear(frame_start), .en(body_byte),
    .idx(byte_idx), .data(rx_d), .local_addr(local_addr), .dest_ok(dest_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_data   <= 8'h00;
      stat_valid <= 1'b0;
      stat_good  <= 1'b0;
    end else begin
      out_valid  <= body_byte;
      if (body_byte) out_data <= rx_d;
      stat_valid <= frame_end;
      if (frame_end) stat_good <= frame_verdict(sfd_seen, err_q, len_ok, crc_ok, dest_ok);
      else           stat_good <= 1'b0;
    end
  end

endmodule

// File: rtl/efc_checker.sv
module efc_checker (
  input logic clk,
  input logic rst_n,
  input logic rx_dv,
  input logic rx_er,
  input logic out_valid,
  input logic stat_valid,
  input logic stat_good,
  input logic frame_active,
  input logic sfd_seen,
  input logic err_seen,
  input logic len_ok,
  input logic crc_ok,
  input logic dest_ok
);

  AST_STAT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |=> !stat_valid); // R8

  AST_STAT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> ($past(frame_active) && !$past(rx_dv))); // R8

  AST_OUT_AFTER_SFD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(rx_dv) && $past(sfd_seen))); // R2

  AST_NO_OUT_WITH_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> !out_valid); // R2

  AST_GOOD_NEEDS_CHECKS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && stat_good) |-> (len_ok && crc_ok && dest_ok)); // R3

  AST_ERR_GIVES_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && err_seen) |-> !stat_good); // R6

  AST_ER_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_active && rx_dv && rx_er) |=> err_seen); // R6

endmodule

bind eth_rx_frame_check efc_checker u_chk (.*);

// File: tb/eth_rx_frame_check_test.sv
module eth_rx_frame_check_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [47:0] MY_ADDR = 48'h02_AB_CD_EF_01_23;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_dv, rx_er;
  logic [7:0]  rx_d;
  logic        out_valid, stat_valid, stat_good;
  logic [7:0]  out_data;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  logic [7:0] raw  [0:2047];
  logic [7:0] body [0:2047];
  logic [7:0] got  [0:2047];
  int got_n  = 0;
  int stat_n = 0;
  logic last_good = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eth_rx_frame_check uut (
    .clk(clk), .rst_n(rst_n), .rx_dv(rx_dv), .rx_er(rx_er), .rx_d(rx_d),
    .local_addr(MY_ADDR), .out_valid(out_valid), .out_data(out_data),
    .stat_valid(stat_valid), .stat_good(stat_good)
  );

  always @(negedge clk) begin
    if (out_valid && got_n < 2048) begin
      got[got_n] = out_data;
      got_n = got_n + 1;
    end
    if (stat_valid) begin
      stat_n = stat_n + 1;
      last_good = stat_good;
    end
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 190000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_checks = n_checks + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // Bit-serial reference CRC, LSB first, register before final inversion.
  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] r = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = r[0] ^ body[i][b];
        r  = {1'b0, r[31:1]};
        if (fb) r = r ^ 32'hEDB88320;
      end
    end
    return r;
  endfunction

  // npre: count of 0x55; sfd: delimiter byte used; blen: bytes after delimiter
  // incl. FCS; er_at: raw index carrying rx_er (-1 none); cut: burst ends after preamble.
  task automatic run_frame(input int npre, input logic [7:0] sfd, input int blen,
                           input logic [47:0] dst, input bit bad_crc, input int er_at,
                           input bit cut, input string tag);
    int rn;
    logic [31:0] c;
    bit pre_ok, len_ok, dst_ok, exp_good, data_ok;
    int fwd_exp;
    for (int i = 0; i < 6; i++) body[i] = dst[47-8*i -: 8];
    for (int i = 6; i < blen - 4; i++) body[i] = 8'($urandom);
    c = ~ref_crc(blen - 4);
    for (int i = 0; i < 4; i++) body[blen-4+i] = c[8*i +: 8];
    if (bad_crc) body[blen-1] = body[blen-1] ^ 8'h10;
    rn = 0;
    for (int i = 0; i < npre; i++) begin raw[rn] = 8'h55; rn = rn + 1; end
    raw[rn] = sfd; rn = rn + 1;
    if (cut) rn = npre;
    else for (int i = 0; i < blen; i++) begin raw[rn] = body[i]; rn = rn + 1; end

    pre_ok  = (npre >= 1) && (sfd == 8'hD5) && !cut;
    len_ok  = (blen >= 64) && (blen <= 1518);
    dst_ok  = (dst == MY_ADDR) || (dst == 48'hFFFF_FFFF_FFFF);
    exp_good = pre_ok && len_ok && dst_ok && !bad_crc && (er_at < 0 || er_at >= rn ? 1'b1 : 1'b0);
    if (er_at >= rn) exp_good = pre_ok && len_ok && dst_ok && !bad_crc;
    fwd_exp = pre_ok ? blen : 0;

    got_n = 0;
    stat_n = 0;
    for (int i = 0; i < rn; i++) begin
      @(negedge clk);
      rx_dv = 1'b1;
      rx_d  = raw[i];
      rx_er = (i == er_at);
    end
    @(negedge clk);
    rx_dv = 1'b0;
    rx_er = 1'b0;
    rx_d  = 8'h00;
    repeat (4) @(negedge clk);

    check(stat_n == 1, {tag, " R8 status pulse count"}, stat_n, 1);
    check(last_good == exp_good, {tag, " R8 verdict"}, int'(last_good), int'(exp_good));
    data_ok = (got_n == fwd_exp);
    if (data_ok) for (int i = 0; i < got_n; i++) if (got[i] != body[i]) data_ok = 0;
    check(data_ok, {tag, " R2 forwarded bytes (count)"}, got_n, fwd_exp);
  endtask

  initial begin
    rst_n = 1'b0;
    rx_dv = 1'b0;
    rx_er = 1'b0;
    rx_d  = 8'h00;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(!out_valid && !stat_valid, "R9 reset outputs", int'(out_valid) + int'(stat_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!out_valid && !stat_valid, "R9 idle after reset", int'(out_valid) + int'(stat_valid), 0);

    run_frame(7, 8'hD5, 64,   MY_ADDR, 0, -1, 0, "R3 min length");
    run_frame(7, 8'hD5, 63,   MY_ADDR, 0, -1, 0, "R3 one short");
    run_frame(7, 8'hD5, 1518, MY_ADDR, 0, -1, 0, "R3 max length");
    run_frame(7, 8'hD5, 1519, MY_ADDR, 0, -1, 0, "R3 one long");
    run_frame(1, 8'hD5, 80,   48'hFFFF_FFFF_FFFF, 0, -1, 0, "R5 broadcast");
    run_frame(3, 8'hD5, 80,   MY_ADDR ^ 48'h1, 0, -1, 0, "R5 last addr byte off");
    run_frame(3, 8'hD5, 80,   48'h01_00_5E_00_00_01, 0, -1, 0, "R5 group addr");
    run_frame(0, 8'hD5, 80,   MY_ADDR, 0, -1, 0, "R1 sfd only");
    run_frame(4, 8'h57, 80,   MY_ADDR, 0, -1, 0, "R1 stray byte");
    run_frame(5, 8'hD5, 80,   MY_ADDR, 0, -1, 1, "R7 cut before sfd");
    run_frame(7, 8'hD5, 80,   MY_ADDR, 0, 87, 0, "R6 er on last byte");
    run_frame(7, 8'hD5, 80,   MY_ADDR, 1, -1, 0, "R4 bad fcs");
    run_frame(7, 8'hD5, 100,  MY_ADDR, 0, -1, 0, "R4 good fcs");

    for (int k = 0; k < 30; k++) begin
      int blen, npre, er_at, sel;
      logic [47:0] dst;
      bit bc;
      npre = 1 + int'($urandom_range(7));
      blen = ($urandom_range(9) == 0) ? 1500 + int'($urandom_range(30)) : 56 + int'($urandom_range(150));
      sel  = int'($urandom_range(3));
      dst  = (sel == 0) ? 48'hFFFF_FFFF_FFFF :
             (sel == 1) ? {8'h1E, 8'($urandom), 32'($urandom)} : MY_ADDR;
      bc   = ($urandom_range(5) == 0);
      er_at = ($urandom_range(7) == 0) ? int'($urandom_range(npre + blen)) : -1;
      run_frame(npre, 8'hD5, blen, dst, bc, er_at, 0, "R4 R5 R6 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule